// File: doc/BRIEF.md
# Protected Address Lookup Table

This block sits in a tile's network interface, between one core's address output and the on-chip network. The core's MMU has already produced a 32-bit physical address. The block uses the top byte of that address to choose one of 256 table entries. The entry names the destination resource: a tile number, a port code and ten extension bits. The block places the extension bits in front of the 24-bit in-region offset to form a 34-bit system-wide address. A lookup that lands on an invalid entry returns a fault instead of a route, so no downstream request can be formed from it.

The table is itself reached through a memory-mapped configuration port. Every configuration access carries the identifier of the core that issued it. One master core may change entries. Its identifier is latched from a strap input while reset is held. Writes from any other core are dropped, and a sticky violation flag records that one was attempted. This keeps one partition from widening its own reach into another partition's memory or devices. The master reads the flag and clears it through the same port.

Top module: `addr_lut_guard`

## Requirements
- R1: A lookup presented with `req_valid` gives its result in the next cycle. The fields come from entry `req_addr[31:24]`. `rsp_sysaddr` is `{ext, req_addr[23:0]}`, and `rsp_tile` and `rsp_port` are the entry's tile and port.
- R2: `rsp_valid` is high exactly in the cycle after each cycle with `req_valid`, and low otherwise. This holds for back-to-back lookups too.
- R3: A lookup on an invalid entry sets `rsp_fault`, and `rsp_tile`, `rsp_port` and `rsp_sysaddr` are all zero. A valid lookup has `rsp_fault` low.
- R4: After reset every entry is invalid and the violation flag is clear.
- R5: The master identifier is the value of `master_strap` while `rst` is high. Changes to the strap after reset have no effect.
- R6: A master write with `cfg_sel`=0 stores `cfg_wdata` into entry `cfg_index`. The layout is bit 19 valid, bits 18:13 tile, bits 12:10 port and bits 9:0 ext. A lookup issued in the cycle after the write sees the new contents.
- R7: A configuration write from any core other than the master leaves every entry unchanged. This includes a write with `cfg_sel`=1, which does not clear the flag. Any such write sets the violation flag.
- R8: The violation flag stays set until the master writes `cfg_sel`=1 with `cfg_wdata[0]`=1. A master write with `cfg_wdata[0]`=0 leaves it set.
- R9: A configuration read gives `cfg_rvalid` in the next cycle. For the master, `cfg_sel`=0 returns the entry in the R6 layout, or all zero if the entry is invalid. For the master, `cfg_sel`=1 returns the flag in bit 0 with the other bits zero. A read from a non-master core returns zero.
- R10: A lookup and a master write to the same entry in the same cycle: the lookup uses the entry's old contents.
- R11: Port codes pass through unchanged: 0 on-tile buffer, 1 DRAM controller, 2 remote tile, 3 I/O. The reserved codes 4 to 7 also pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_strap | input | 6 | Master core identifier, latched during reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Core physical address |
| rsp_valid | output | 1 | Lookup result strobe |
| rsp_fault | output | 1 | Lookup hit an invalid entry |
| rsp_tile | output | 6 | Destination tile number |
| rsp_port | output | 3 | Destination port code |
| rsp_sysaddr | output | 34 | System-wide address |
| cfg_valid | input | 1 | Configuration access strobe |
| cfg_write | input | 1 | 1 write, 0 read |
| cfg_sel | input | 1 | 0 table entry, 1 violation status |
| cfg_core_id | input | 6 | Identifier of the requesting core |
| cfg_index | input | 8 | Entry number |
| cfg_wdata | input | 20 | Write data |
| cfg_rvalid | output | 1 | Read data strobe |
| cfg_rdata | output | 20 | Read data |

## Verification
The bench changes the strap after reset and then writes from the new strap value. A design that tracks the live strap would accept those writes and change routes the bench still expects to be old. Non-master writes are aimed at both an entry and the status clear. A leaky guard would show a changed route, or a flag read back as zero. A lookup and a write to the same entry are issued in one cycle. A design that forwards the write would report a route where a fault is expected. Reserved port codes, the all-ones index and an entry written with its valid bit low are all exercised. A design that masks port codes, mis-slices the index or ignores the valid bit would return wrong fields.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 8;
    localparam int CORE_W = 6;
    localparam int TILE_W = 6;
    localparam int PORT_W = 3;
    localparam int EXT_W  = 10;
    localparam int OFF_W  = ADDR_W - IDX_W;
    localparam int SYS_W  = EXT_W + OFF_W;
    localparam int DEPTH  = 1 << IDX_W;

    typedef struct packed {
        logic [TILE_W-1:0] tile;
        logic [PORT_W-1:0] port;
        logic [EXT_W-1:0]  ext;
    } xlt_payload_t;

    typedef struct packed {
        logic         vld;
        xlt_payload_t pay;
    } xlt_entry_t;

    localparam int ENT_W = $bits(xlt_entry_t);

    typedef enum logic {
        CFG_SEL_ENTRY  = 1'b0,
        CFG_SEL_STATUS = 1'b1
    } cfg_sel_e;

    typedef struct packed {
        logic              fault;
        logic [TILE_W-1:0] tile;
        logic [PORT_W-1:0] port;
        logic [SYS_W-1:0]  sys;
    } xlt_rsp_t;

    function automatic logic [SYS_W-1:0] join_sys(input logic [EXT_W-1:0] ext,
                                                   input logic [OFF_W-1:0] off);
        return {ext, off};
    endfunction
endpackage

// File: rtl/xlt_cfg_guard.sv
module xlt_cfg_guard
    import xlt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CORE_W-1:0] master_strap,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic              cfg_sel,
    input  logic [CORE_W-1:0] cfg_core_id,
    input  logic              clr_bit,
    output logic [CORE_W-1:0] master_q,
    output logic              is_master,
    output logic              entry_we,
    output logic              viol_q
);
    logic wr_req;

    assign is_master = (cfg_core_id == master_q);
    assign wr_req    = cfg_valid && cfg_write;
    assign entry_we  = wr_req && is_master && (cfg_sel == CFG_SEL_ENTRY);

    always_ff @(posedge clk) begin
        if (rst) begin
            master_q <= master_strap;
            viol_q   <= 1'b0;
        end else if (wr_req) begin
            if (!is_master)
                viol_q <= 1'b1;
            else if ((cfg_sel == CFG_SEL_STATUS) && clr_bit)
                viol_q <= 1'b0;
        end
    end
endmodule

// File: rtl/xlt_entry_store.sv
module xlt_entry_store
    import xlt_pkg::*;
#(
    parameter int N_ENT = DEPTH,
    localparam int AW   = $clog2(N_ENT)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [AW-1:0] waddr,
    input  xlt_entry_t   wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output xlt_entry_t   rdata_a,
    output xlt_entry_t   rdata_b
);
    logic         vld_q [N_ENT];
    xlt_payload_t pay_q [N_ENT];

    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_ent
        logic hit;
        assign hit = we && (waddr == AW'(gi));

        always_ff @(posedge clk) begin
            if (rst)
                vld_q[gi] <= 1'b0;
            else if (hit)
                vld_q[gi] <= wdata.vld;
        end

        always_ff @(posedge clk) begin
            if (hit)
                pay_q[gi] <= wdata.pay;
        end
    end

    always_comb begin
        rdata_a = '0;
        if (vld_q[raddr_a]) begin
            rdata_a.vld = 1'b1;
            rdata_a.pay = pay_q[raddr_a];
        end
        rdata_b = '0;
        if (vld_q[raddr_b]) begin
            rdata_b.vld = 1'b1;
            rdata_b.pay = pay_q[raddr_b];
        end
    end
endmodule

// File: rtl/xlt_resp_stage.sv
module xlt_resp_stage
    import xlt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [OFF_W-1:0] req_off,
    input  xlt_entry_t       ent,
    output logic             rsp_valid,
    output xlt_rsp_t         rsp_q
);
    xlt_rsp_t rsp_d;

    always_comb begin
        rsp_d = '0;
        if (!ent.vld) begin
            rsp_d.fault = 1'b1;
        end else begin
            rsp_d.tile = ent.pay.tile;
            rsp_d.port = ent.pay.port;
            rsp_d.sys  = join_sys(ent.pay.ext, req_off);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_q     <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid)
                rsp_q <= rsp_d;
        end
    end
endmodule

// File: rtl/addr_lut_guard.sv
module addr_lut_guard
    import xlt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CORE_W-1:0] master_strap,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [TILE_W-1:0] rsp_tile,
    output logic [PORT_W-1:0] rsp_port,
    output logic [SYS_W-1:0]  rsp_sysaddr,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic              cfg_sel,
    input  logic [CORE_W-1:0] cfg_core_id,
    input  logic [IDX_W-1:0]  cfg_index,
    input  logic [ENT_W-1:0]  cfg_wdata,
    output logic              cfg_rvalid,
    output logic [ENT_W-1:0]  cfg_rdata
);
    logic [CORE_W-1:0] master_q;
    logic              is_master;
    logic              entry_we;
    logic              viol_q;
    xlt_entry_t        lk_ent;
    xlt_entry_t        cf_ent;
    xlt_rsp_t          rsp_q;
    logic [ENT_W-1:0]  rdata_d;

    xlt_cfg_guard guard_i (
        .clk         (clk),
        .rst         (rst),
        .master_strap(master_strap),
        .cfg_valid   (cfg_valid),
        .cfg_write   (cfg_write),
        .cfg_sel     (cfg_sel),
        .cfg_core_id (cfg_core_id),
        .clr_bit     (cfg_wdata[0]),
        .master_q    (master_q),
        .is_master   (is_master),
        .entry_we    (entry_we),
        .viol_q      (viol_q)
    );

    xlt_entry_store #(.N_ENT(DEPTH)) store_i (
        .clk    (clk),
        .rst    (rst),
        .we     (entry_we),
        .waddr  (cfg_index),
        .wdata  (xlt_entry_t'(cfg_wdata)),
        .raddr_a(req_addr[ADDR_W-1 -: IDX_W]),
        .raddr_b(cfg_index),
        .rdata_a(lk_ent),
        .rdata_b(cf_ent)
    );

    xlt_resp_stage resp_i (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_off  (req_addr[OFF_W-1:0]),
        .ent      (lk_ent),
        .rsp_valid(rsp_valid),
        .rsp_q    (rsp_q)
    );

    assign rsp_fault   = rsp_q.fault;
    assign rsp_tile    = rsp_q.tile;
    assign rsp_port    = rsp_q.port;
    assign rsp_sysaddr = rsp_q.sys;

    always_comb begin
        if (!is_master)
            rdata_d = '0;
        else if (cfg_sel == CFG_SEL_STATUS)
            rdata_d = ENT_W'(viol_q);
        else
            rdata_d = cf_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= '0;
        end else begin
            cfg_rvalid <= cfg_valid && !cfg_write;
            if (cfg_valid && !cfg_write)
                cfg_rdata <= rdata_d;
        end
    end
endmodule

// File: rtl/addr_lut_guard_chk.sv
module addr_lut_guard_chk
    import xlt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [TILE_W-1:0] rsp_tile,
    input logic [PORT_W-1:0] rsp_port,
    input logic [SYS_W-1:0]  rsp_sysaddr,
    input logic              cfg_valid,
    input logic              cfg_write,
    input logic              cfg_sel,
    input logic [CORE_W-1:0] cfg_core_id,
    input logic              cfg_rvalid,
    input logic [CORE_W-1:0] master_q,
    input logic              entry_we,
    input logic              viol_q
);
    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r1_offset_kept: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_fault || (rsp_sysaddr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0]))));

    a_r3_fault_zeroed: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_tile == '0 && rsp_port == '0 && rsp_sysaddr == '0));

    a_r7_foreign_write_blocked: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && cfg_write && cfg_core_id != master_q) |-> !entry_we);

    a_r7_foreign_write_flags: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && cfg_write && cfg_core_id != master_q) |=> viol_q);

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (viol_q && !(cfg_valid && cfg_write && cfg_sel && cfg_core_id == master_q)) |=> viol_q);

    a_r9_read_latency: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && !cfg_write) |=> cfg_rvalid);
endmodule

bind addr_lut_guard addr_lut_guard_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .rsp_tile   (rsp_tile),
    .rsp_port   (rsp_port),
    .rsp_sysaddr(rsp_sysaddr),
    .cfg_valid  (cfg_valid),
    .cfg_write  (cfg_write),
    .cfg_sel    (cfg_sel),
    .cfg_core_id(cfg_core_id),
    .cfg_rvalid (cfg_rvalid),
    .master_q   (master_q),
    .entry_we   (entry_we),
    .viol_q     (viol_q)
);

// File: tb/addr_lut_guard_tb_top.sv
`timescale 1ns/1ps
module addr_lut_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  master_strap;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        rsp_valid, rsp_fault;
    logic [5:0]  rsp_tile;
    logic [2:0]  rsp_port;
    logic [33:0] rsp_sysaddr;
    logic        cfg_valid, cfg_write, cfg_sel;
    logic [5:0]  cfg_core_id;
    logic [7:0]  cfg_index;
    logic [19:0] cfg_wdata;
    logic        cfg_rvalid;
    logic [19:0] cfg_rdata;

    always #10 clk = ~clk;

    addr_lut_guard dut_i (
        .clk(clk), .rst(rst), .master_strap(master_strap),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_tile(rsp_tile),
        .rsp_port(rsp_port), .rsp_sysaddr(rsp_sysaddr),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_sel(cfg_sel),
        .cfg_core_id(cfg_core_id), .cfg_index(cfg_index), .cfg_wdata(cfg_wdata),
        .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata)
    );

    typedef struct packed {
        logic        fault;
        logic [5:0]  tile;
        logic [2:0]  port;
        logic [33:0] sys;
    } exp_t;

    localparam logic [5:0] MASTER = 6'd5;
    localparam logic [5:0] OTHER  = 6'd9;

    logic [19:0] model [256];
    logic        viol_m;
    exp_t        exp_q [$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic exp_t predict(input logic [31:0] a);
        exp_t e;
        logic [19:0] m;
        m = model[a[31:24]];
        e = '0;
        if (!m[19]) e.fault = 1'b1;
        else begin
            e.tile = m[18:13];
            e.port = m[12:10];
            e.sys  = {m[9:0], a[23:0]};
        end
        return e;
    endfunction

    // monitor: pops expected lookup results as the design produces them
    always begin
        exp_t e, got;
        @(negedge clk);
        #1;
        if (!rst && rsp_valid) begin
            got = {rsp_fault, rsp_tile, rsp_port, rsp_sysaddr};
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected response", 64'(got), 64'(0));
            end else begin
                e = exp_q.pop_front();
                check(got == e, "R1/R3/R11 lookup result", 64'(got), 64'(e));
            end
        end
    end

    task automatic xl(input logic [31:0] a);
        @(negedge clk);
        cfg_valid = 1'b0;
        req_valid = 1'b1;
        req_addr  = a;
        exp_q.push_back(predict(a));
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        cfg_valid = 1'b0;
    endtask

    task automatic cfg_wr(input logic [5:0] core, input logic sel, input logic [7:0] idx,
                          input logic [19:0] d);
        @(negedge clk);
        req_valid   = 1'b0;
        cfg_valid   = 1'b1;
        cfg_write   = 1'b1;
        cfg_sel     = sel;
        cfg_core_id = core;
        cfg_index   = idx;
        cfg_wdata   = d;
        if (core != MASTER) viol_m = 1'b1;
        else if (sel == 1'b0) model[idx] = d;
        else if (d[0]) viol_m = 1'b0;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic cfg_rd(input logic [5:0] core, input logic sel, input logic [7:0] idx,
                          input logic [19:0] expv, input string tag);
        @(negedge clk);
        req_valid   = 1'b0;
        cfg_valid   = 1'b1;
        cfg_write   = 1'b0;
        cfg_sel     = sel;
        cfg_core_id = core;
        cfg_index   = idx;
        @(negedge clk);
        cfg_valid = 1'b0;
        #1;
        check(cfg_rvalid == 1'b1, "R9 read strobe", 64'(cfg_rvalid), 64'(1));
        check(cfg_rdata == expv, tag, 64'(cfg_rdata), 64'(expv));
    endtask

    function automatic logic [19:0] ent(input logic v, input logic [5:0] t,
                                        input logic [2:0] p, input logic [9:0] x);
        return {v, t, p, x};
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            check(1'b0, "watchdog expired", 64'(0), 64'(1));
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 20'h0;
        viol_m = 1'b0;
        rst = 1'b1; master_strap = MASTER;
        req_valid = 0; req_addr = 0;
        cfg_valid = 0; cfg_write = 0; cfg_sel = 0; cfg_core_id = 0; cfg_index = 0; cfg_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        master_strap = OTHER;  // R5: strap change after reset must not move the master
        @(negedge clk); #1;
        check(rsp_valid == 1'b0 && cfg_rvalid == 1'b0, "R4 reset outputs idle",
              64'({rsp_valid, cfg_rvalid}), 64'(0));

        // R4: status clear and entries invalid after reset
        cfg_rd(MASTER, 1'b1, 8'h00, 20'h0, "R4 flag clear after reset");
        cfg_rd(MASTER, 1'b0, 8'h80, 20'h0, "R4 entry invalid after reset");
        xl(32'h0012_3456); xl(32'hFF00_0001); idle();

        // R6/R11: master programs entries across port codes
        cfg_wr(MASTER, 1'b0, 8'h00, ent(1, 6'd3,  3'd0, 10'h155));
        cfg_wr(MASTER, 1'b0, 8'h80, ent(1, 6'd12, 3'd1, 10'h2A0));
        cfg_wr(MASTER, 1'b0, 8'hFF, ent(1, 6'd63, 3'd2, 10'h3FF));
        cfg_wr(MASTER, 1'b0, 8'h41, ent(1, 6'd7,  3'd7, 10'h001));
        cfg_wr(MASTER, 1'b0, 8'h42, ent(1, 6'd8,  3'd3, 10'h0F0));
        cfg_wr(MASTER, 1'b0, 8'h10, ent(0, 6'd9,  3'd1, 10'h123));
        // R1/R2: back-to-back lookups, varied offsets
        xl(32'h00AB_CDEF); xl(32'h8000_0000); xl(32'hFFFF_FFFF);
        xl(32'h4112_3456); xl(32'h4200_00FF); xl(32'h1055_5555);
        idle();
        @(negedge clk); #1;
        check(rsp_valid == 1'b0, "R2 no response when idle", 64'(rsp_valid), 64'(0));

        // R9: entry reads
        cfg_rd(MASTER, 1'b0, 8'hFF, ent(1, 6'd63, 3'd2, 10'h3FF), "R9 master entry read");
        cfg_rd(MASTER, 1'b0, 8'h10, 20'h0, "R9 invalid entry reads zero");
        cfg_rd(OTHER,  1'b0, 8'hFF, 20'h0, "R9 non-master read zero");

        // R7/R5: non-master (equal to the new strap value) writes rejected
        cfg_wr(OTHER, 1'b0, 8'h80, ent(1, 6'd1, 3'd3, 10'h000));
        xl(32'h8000_1234); idle();
        cfg_rd(MASTER, 1'b0, 8'h80, ent(1, 6'd12, 3'd1, 10'h2A0), "R7 entry unchanged");
        cfg_rd(MASTER, 1'b1, 8'h00, 20'h1, "R7 violation flag set");
        cfg_wr(OTHER, 1'b1, 8'h00, 20'h1);
        cfg_rd(MASTER, 1'b1, 8'h00, 20'h1, "R7 non-master cannot clear flag");
        cfg_rd(OTHER,  1'b1, 8'h00, 20'h0, "R9 non-master status read zero");
        // R8: clear behaviour
        cfg_wr(MASTER, 1'b1, 8'h00, 20'h0);
        cfg_rd(MASTER, 1'b1, 8'h00, 20'h1, "R8 zero write keeps flag");
        cfg_wr(MASTER, 1'b1, 8'h00, 20'h1);
        cfg_rd(MASTER, 1'b1, 8'h00, 20'h0, "R8 flag cleared by master");

        // R10: same-cycle lookup and write to one entry
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h2200_0777;
        exp_q.push_back(predict(32'h2200_0777));
        cfg_valid = 1'b1; cfg_write = 1'b1; cfg_sel = 1'b0; cfg_core_id = MASTER;
        cfg_index = 8'h22; cfg_wdata = ent(1, 6'd20, 3'd1, 10'h0AA);
        model[8'h22] = ent(1, 6'd20, 3'd1, 10'h0AA);
        xl(32'h2200_0777);  // R6: next-cycle lookup sees new entry
        idle();
        // R6: invalidate by rewrite
        cfg_wr(MASTER, 1'b0, 8'h22, ent(0, 6'd20, 3'd1, 10'h0AA));
        xl(32'h2200_0001); idle();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 every lookup answered", 64'(exp_q.size()), 64'(0));
        check(viol_m == 1'b0, "R8 model flag consistent", 64'(viol_m), 64'(0));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule